// File: doc/BRIEF.md
# Gated Muxed Clock-Enable Channel Bank

This block turns a small set of parent clock-enable pulse trains into sixteen independent clock-enable outputs, all in one system clock domain. Each output channel picks one of four parent pulse trains, thins it by a power-of-two ratio of 1, 2, 4 or 8, and can be stopped entirely. Downstream logic uses a channel output as the enable of its own flops, so a channel output is high for exactly one system cycle per divided period.

Software controls the bank through a plain read/write register port with three word-aligned registers. The stop register holds one bit per channel. The source register and the ratio register each hold one 2-bit field per channel. A stopped channel is silent and its divide counter is held at zero, so it restarts at the beginning of a fresh period when it runs again. Source and ratio changes on a running channel wait for the end of the channel's current divided period, so no output period is shortened or stretched by a reprogram.

Top module: `clk_chan_bank`

## Requirements
- R1: A channel output `ch_en[i]` is high only in a cycle where the parent pulse selected for channel i is high on `parent_en`.
- R2: The 2-bit field at bits 2i+1:2i of the source register (byte offset 0x4) selects `parent_en` index 0 to 3 for channel i.
- R3: Bit i of the stop register (byte offset 0x0) set to 1 keeps `ch_en[i]` low; a 0 lets channel i run.
- R4: With value d in the 2-bit field at bits 2i+1:2i of the ratio register (byte offset 0x8), a running channel drives `ch_en[i]` high in the same cycle as every 2^d-th pulse of its selected parent, counted from the moment it started running.
- R5: While a channel is stopped its count is held at zero, so after it is released its first output comes on exactly the 2^d-th selected parent pulse, whatever the count was before it was stopped.
- R6: A source or ratio change written while a channel runs takes effect only after the channel's next output pulse; the pulse ending the current period still follows the old setting.
- R7: After reset the stop register reads 0x0000FFFF, the source and ratio registers read 0, and every `ch_en` bit stays low.
- R8: A read at offset 0x0, 0x4 or 0x8 returns the last value written there, with stop register bits 31:16 reading 0; a read at offset 0xC returns 0.
- R9: A write to offset 0xC changes no register and no channel output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address of the register access; bits 1:0 are ignored |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Read data of the register at `addr`, combinational |
| parent_en | input | 4 | Parent clock-enable pulse trains, one bit per parent |
| ch_en | output | 16 | Channel clock-enable outputs, one bit per channel |

## Verification
The main function is swept with each parent pulsing at a different period (every 1, 2, 3 and 4 cycles), so a wrong source choice shows up as a wrong pulse count, and with all sixteen source/ratio pairs spread over the channels in two transposed layouts, so both fields are tried for every value on several channels. A mixed stop pattern separates channels that must stay silent from neighbours that must keep counting, and re-stopping after a partial run tells a cleared counter from a held one. A dedicated sequence reprograms the ratio in mid-period with one parent pulsing every cycle; the position of the first output and the total count tell a boundary-aligned update from an immediate one.

// File: rtl/chb_pkg.sv
`timescale 1ns/1ps
package chb_pkg;

   // Register word index decoded from the byte address
   typedef enum logic [1:0] {
      RSEL_STOP  = 2'd0,
      RSEL_SRC   = 2'd1,
      RSEL_RATIO = 2'd2,
      RSEL_NONE  = 2'd3
   } reg_sel_e;

   // Number of register words in use
   localparam int unsigned NUM_REGS = 3;

   // Counter width for a ratio field of the given width: the largest
   // ratio is 2**(2**w - 1), whose terminal count needs 2**w - 1 bits
   function automatic int unsigned cnt_width(input int unsigned w);
      return (1 << w) - 1;
   endfunction

endpackage

// File: rtl/chb_regs.sv
`timescale 1ns/1ps
module chb_regs
   import chb_pkg::*;
#(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned DIV_W  = 2,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [DATA_W-1:0]         rd_data,
   output logic [NUM_CH-1:0]         stop_q,
   output logic [NUM_CH*SEL_W-1:0]   src_q,
   output logic [NUM_CH*DIV_W-1:0]   ratio_q
);

   localparam int unsigned WORD_W = ADDR_W - 2;
   localparam int unsigned SRC_BITS = NUM_CH * SEL_W;
   localparam int unsigned RAT_BITS = NUM_CH * DIV_W;

   logic [WORD_W-1:0] word;
   reg_sel_e          rsel;

   assign word = addr[ADDR_W-1:2];

   always_comb begin
      if (word == WORD_W'(0))      rsel = RSEL_STOP;
      else if (word == WORD_W'(1)) rsel = RSEL_SRC;
      else if (word == WORD_W'(2)) rsel = RSEL_RATIO;
      else                         rsel = RSEL_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_q  <= '1;
         src_q   <= '0;
         ratio_q <= '0;
      end else if (wr_en) begin
         case (rsel)
            RSEL_STOP:  stop_q  <= wr_data[NUM_CH-1:0];
            RSEL_SRC:   src_q   <= wr_data[SRC_BITS-1:0];
            RSEL_RATIO: ratio_q <= wr_data[RAT_BITS-1:0];
            default:    ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (rsel)
         RSEL_STOP:  rd_data[NUM_CH-1:0]   = stop_q;
         RSEL_SRC:   rd_data[SRC_BITS-1:0] = src_q;
         RSEL_RATIO: rd_data[RAT_BITS-1:0] = ratio_q;
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/chb_channel.sv
`timescale 1ns/1ps
module chb_channel
   import chb_pkg::*;
#(
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned DIV_W   = 2,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [(1<<SEL_W)-1:0]  parent_en,
   input  logic                   stop,
   input  logic [SEL_W-1:0]       src_cfg,
   input  logic [DIV_W-1:0]       ratio_cfg,
   output logic                   pulse
);

   localparam int unsigned CNT_W = cnt_width(DIV_W);

   logic [SEL_W-1:0] src_cur;
   logic [DIV_W-1:0] ratio_cur;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             par_hit;
   logic             at_end;
   logic             fire;

   // terminal count is 2**ratio - 1: clear the shifted-in ones
   assign limit   = ~({CNT_W{1'b1}} << ratio_cur);
   assign par_hit = parent_en[src_cur];
   assign at_end  = (cnt_q == limit);
   assign fire    = !stop && par_hit && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         src_cur   <= '0;
         ratio_cur <= '0;
      end else if (stop) begin
         // stopped: counter parked at zero, settings follow the registers
         cnt_q     <= '0;
         src_cur   <= src_cfg;
         ratio_cur <= ratio_cfg;
      end else if (par_hit) begin
         if (at_end) begin
            cnt_q     <= '0;
            src_cur   <= src_cfg;
            ratio_cur <= ratio_cfg;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   generate
      if (REG_OUT) begin : g_flop_out
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= fire;
         end
         assign pulse = pulse_q;
      end else begin : g_comb_out
         assign pulse = fire;
      end
   endgenerate

endmodule

// File: rtl/clk_chan_bank.sv
`timescale 1ns/1ps
module clk_chan_bank
   import chb_pkg::*;
#(
   parameter int unsigned NUM_CH  = 16,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned DIV_W   = 2,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter bit          REG_OUT = 1'b0,
   localparam int unsigned NUM_PAR = 1 << SEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_PAR-1:0] parent_en,
   output logic [NUM_CH-1:0]  ch_en
);

   // elaboration-time parameter checks
   generate
      if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
         $error("NUM_CH must be between 1 and DATA_W");
      end
      if (NUM_CH * SEL_W > DATA_W) begin : g_bad_src
         $error("source fields exceed register width");
      end
      if (NUM_CH * DIV_W > DATA_W) begin : g_bad_ratio
         $error("ratio fields exceed register width");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must cover three word registers");
      end
      if (SEL_W < 1 || DIV_W < 1 || DIV_W > 4) begin : g_bad_field
         $error("field widths out of range");
      end
   endgenerate

   logic [NUM_CH-1:0]       stop_q;
   logic [NUM_CH*SEL_W-1:0] src_q;
   logic [NUM_CH*DIV_W-1:0] ratio_q;

   chb_regs #(
      .NUM_CH (NUM_CH),
      .SEL_W  (SEL_W),
      .DIV_W  (DIV_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .stop_q  (stop_q),
      .src_q   (src_q),
      .ratio_q (ratio_q)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         chb_channel #(
            .SEL_W   (SEL_W),
            .DIV_W   (DIV_W),
            .REG_OUT (REG_OUT)
         ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .parent_en (parent_en),
            .stop      (stop_q[i]),
            .src_cfg   (src_q[i*SEL_W +: SEL_W]),
            .ratio_cfg (ratio_q[i*DIV_W +: DIV_W]),
            .pulse     (ch_en[i])
         );
      end
   endgenerate

endmodule

// File: rtl/chb_checker.sv
`timescale 1ns/1ps
module chb_checker #(
   parameter int unsigned NUM_CH  = 16,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned DIV_W   = 2,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter bit          REG_OUT = 1'b0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic [ADDR_W-1:0]       addr,
   input logic [DATA_W-1:0]       wr_data,
   input logic [(1<<SEL_W)-1:0]   parent_en,
   input logic [NUM_CH-1:0]       ch_en,
   input logic [NUM_CH-1:0]       stop_q,
   input logic [NUM_CH*SEL_W-1:0] src_q,
   input logic [NUM_CH*DIV_W-1:0] ratio_q
);

   // R7
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (stop_q == '1 && src_q == '0 && ratio_q == '0));

   // R9
   stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[ADDR_W-1:2] > 2) |=>
         ($stable(stop_q) && $stable(src_q) && $stable(ratio_q)));

   // R8
   stop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[ADDR_W-1:2] == 0) |=>
         (stop_q == $past(wr_data[NUM_CH-1:0])));

   generate
      if (!REG_OUT) begin : g_comb_chk
         // R1
         parent_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en != '0) |-> (parent_en != '0));
         for (genvar i = 0; i < NUM_CH; i++) begin : g_stop
            // R3
            stopped_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
               stop_q[i] |-> !ch_en[i]);
         end
      end
   endgenerate

endmodule

bind clk_chan_bank chb_checker #(
   .NUM_CH  (NUM_CH),
   .SEL_W   (SEL_W),
   .DIV_W   (DIV_W),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .wr_data   (wr_data),
   .parent_en (parent_en),
   .ch_en     (ch_en),
   .stop_q    (stop_q),
   .src_q     (src_q),
   .ratio_q   (ratio_q)
);

// File: tb/clk_chan_bank_test.sv
`timescale 1ns/1ps
module clk_chan_bank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  parent_en = '0;
   logic [15:0] ch_en;

   int checks = 0;
   int fails = 0;
   int sel_a [16];
   int div_a [16];
   int cnt_a [16];
   int first_a [16];
   int bad_par;

   clk_chan_bank uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .parent_en (parent_en),
      .ch_en     (ch_en)
   );

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   // parent k pulses when the phase count is a multiple of k+1
   function automatic logic [3:0] pattern(input int c);
      logic [3:0] p;
      for (int k = 0; k < 4; k++) p[k] = ((c % (k + 1)) == 0);
      return p;
   endfunction

   function automatic int parent_pulses(input int k, input int n);
      return ((n - 1) / (k + 1)) + 1;
   endfunction

   task automatic run(input int n);
      for (int i = 0; i < 16; i++) begin cnt_a[i] = 0; first_a[i] = -1; end
      bad_par = 0;
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         parent_en = pattern(c);
         #1;
         for (int i = 0; i < 16; i++) begin
            if (ch_en[i]) begin
               if (first_a[i] < 0) first_a[i] = c;
               cnt_a[i]++;
               if (!parent_en[sel_a[i]]) bad_par++;
            end
         end
      end
      @(negedge clk);
      parent_en = '0;
   endtask

   function automatic logic [31:0] pack(input int v [16]);
      logic [31:0] w = '0;
      for (int i = 0; i < 16; i++) w[2*i +: 2] = v[i][1:0];
      return w;
   endfunction

   task automatic sweep(input logic [15:0] stop_mask, input int n, input string tag);
      wr(4'h4, pack(sel_a));
      wr(4'h8, pack(div_a));
      wr(4'h0, {16'h0, stop_mask});
      run(n);
      for (int i = 0; i < 16; i++) begin
         int e;
         e = stop_mask[i] ? 0 : (parent_pulses(sel_a[i], n) >> div_a[i]);
         chk(cnt_a[i] == e, $sformatf("%s ch%0d sel=%0d div=%0d", tag, i, sel_a[i], div_a[i]),
             cnt_a[i], e);
      end
      chk(bad_par == 0, "R1 pulse without selected parent", bad_par, 0);
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      // R7: outputs silent while parents pulse during and after reset
      parent_en = 4'hF;
      #1 chk(ch_en == 16'h0, "R7 outputs during reset", ch_en, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1 chk(ch_en == 16'h0, "R7 outputs after reset", ch_en, 0);
      parent_en = '0;
      rd(4'h0, d); chk(d == 32'h0000FFFF, "R7 stop reset", d, 32'h0000FFFF);
      rd(4'h4, d); chk(d == 32'h0, "R7 source reset", d, 0);
      rd(4'h8, d); chk(d == 32'h0, "R7 ratio reset", d, 0);

      // R8: readback
      wr(4'h0, 32'h1234_5678);
      rd(4'h0, d); chk(d == 32'h0000_5678, "R8 stop readback", d, 32'h5678);
      wr(4'h4, 32'hA5C3_0F96);
      rd(4'h4, d); chk(d == 32'hA5C3_0F96, "R8 source readback", d, 32'hA5C30F96);
      wr(4'h8, 32'h5A3C_F069);
      rd(4'h8, d); chk(d == 32'h5A3C_F069, "R8 ratio readback", d, 32'h5A3CF069);
      rd(4'hC, d); chk(d == 32'h0, "R8 unused offset reads zero", d, 0);

      // R9: write to unused offset
      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'h0, d); chk(d == 32'h0000_5678, "R9 stop unchanged", d, 32'h5678);
      rd(4'h4, d); chk(d == 32'hA5C3_0F96, "R9 source unchanged", d, 32'hA5C30F96);
      rd(4'h8, d); chk(d == 32'h5A3C_F069, "R9 ratio unchanged", d, 32'h5A3CF069);
      wr(4'h0, 32'hFFFF);
      wr(4'hC, 32'h0);
      rd(4'h0, d); chk(d == 32'h0000_FFFF, "R9 stop stays all ones", d, 32'hFFFF);
      run(8);
      chk(cnt_a[0] == 0 && cnt_a[15] == 0, "R9 outputs stay silent", cnt_a[0] + cnt_a[15], 0);

      // R2 R4: every source/ratio pair, two layouts
      for (int i = 0; i < 16; i++) begin sel_a[i] = i % 4; div_a[i] = i / 4; end
      sweep(16'h0000, 60, "R2 R4 layout A");
      wr(4'h0, 32'hFFFF);
      for (int i = 0; i < 16; i++) begin sel_a[i] = i / 4; div_a[i] = i % 4; end
      // R5: counters left mid-period above must restart from zero
      sweep(16'h0000, 37, "R4 R5 layout B");
      run(5);
      wr(4'h0, 32'hFFFF);
      sweep(16'h0000, 53, "R5 restart after stop");

      // R3: mixed stop pattern
      wr(4'h0, 32'hFFFF);
      for (int i = 0; i < 16; i++) begin sel_a[i] = (i * 3) % 4; div_a[i] = (i / 2) % 4; end
      sweep(16'hAAAA, 48, "R3 mixed stop");
      wr(4'h0, 32'hFFFF);
      sweep(16'h5A0F, 40, "R3 second stop pattern");

      // R6: ratio change mid-period with parent 0 pulsing every cycle
      wr(4'h0, 32'hFFFF);
      for (int i = 0; i < 16; i++) begin sel_a[i] = 0; div_a[i] = 0; end
      div_a[0] = 3;
      wr(4'h4, 32'h0);
      wr(4'h8, pack(div_a));
      wr(4'h0, 32'hFFFE);
      run(4);
      chk(cnt_a[0] == 0, "R6 no pulse in first half period", cnt_a[0], 0);
      wr(4'h8, 32'h0);
      run(8);
      chk(first_a[0] == 3, "R6 old period completes first", first_a[0], 3);
      chk(cnt_a[0] == 5, "R6 new ratio after boundary", cnt_a[0], 5);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule